// File: doc/BRIEF.md
# Receive Address Filter

This block sits on the receive path of an Ethernet MAC. It inspects the first twelve bytes of every incoming frame, which are the destination address followed by the source address. It then decides whether the frame should be kept or dropped. The decision is made against a bank of perfect-match address entries. Each entry holds a 48-bit address, a mask bit for each of its six bytes and an enable bit. Each entry also has a selector that points it at either the destination or the source address.

Three global modes widen the acceptance:
- Accept-all-multicast lets every group-addressed frame through the destination stage.
- Promiscuous mode keeps every frame.
- Report-all mode keeps every frame but still computes the full filter result, so later logic can act on the status.

Alongside the keep/drop flag, the block reports:
- whether any entry matched,
- the index of the winning entry,
- whether the frame is multicast,
- whether the frame is broadcast.

Configuration is a simple write port: an entry index, a word selector and a 32-bit data word.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_pass`, `st_filt_ok`, `st_hit`, `st_mcast`, `st_bcast` are 0 and `st_idx` is 0; all entries are disabled and all modes are off.
- R2: A byte is accepted when `in_valid` is high. A byte with `in_sof` high starts a frame and clears `dec_valid` at that clock edge. The decision appears at the clock edge that accepts the twelfth byte of the frame, counting the start byte as the first. It then stays unchanged until the next start byte, and bytes after the twelfth have no effect. A new start byte arriving before the twelfth byte restarts the count, and no decision is produced for the cut-short frame.
- R3: Configuration uses `cfg_word`:
  - Word 0 writes address bits 31:0 of entry `cfg_idx`.
  - Word 1 writes address bits 47:32 from data bits 15:0, the byte mask from data bits 21:16, the enable from bit 24 and the source selector from bit 25.
  - Word 2 writes the mode bits: bit 0 promiscuous, bit 1 accept-all-multicast, bit 2 report-all. For word 2, `cfg_idx` is not used.
  - Address bits 47:40 are compared with the first received byte of the address.
  - A write to an index of `N_FILT` or more changes nothing.
- R4: An enabled destination entry (selector 0) matches when every unmasked byte equals the corresponding destination byte. Such a match satisfies the destination stage. `st_filt_ok` is 1 exactly when both the destination stage and the source stage are satisfied.
- R5: Mask bit k set excludes address byte k (byte 0 = first received) from the comparison, so that byte always matches.
- R6: When at least one enabled entry has selector 1, the source address must match one such entry, with the same byte and mask rules, for the source stage to be satisfied. With no enabled source entry, the source stage is always satisfied.
- R7: A frame is multicast when bit 0 of the first destination byte is 1, and broadcast when all six destination bytes are 0xFF. These are reported on `st_mcast` and `st_bcast`. Broadcast always satisfies the destination stage; multicast satisfies it only when accept-all-multicast is on.
- R8: In promiscuous mode `dec_pass` is 1 for every frame.
- R9: In report-all mode `dec_pass` is 1 for every frame, while `st_filt_ok`, `st_hit` and `st_idx` still carry the filter result.
- R10: `st_hit` is 1 when any enabled entry of either kind matches its selected address. `st_idx` is the lowest such index, or 0 when none matches.
- R11: An entry whose enable is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte valid |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Entry index for words 0 and 1 |
| cfg_word | input | 2 | Word selector (0 addr low, 1 addr high/mask/flags, 2 modes) |
| cfg_wdata | input | 32 | Configuration data |
| dec_valid | output | 1 | Decision and status valid |
| dec_pass | output | 1 | Keep the frame |
| st_filt_ok | output | 1 | Address filter result ignoring promiscuous and report-all |
| st_hit | output | 1 | Some enabled entry matched |
| st_idx | output | IW | Lowest matching entry index |
| st_mcast | output | 1 | Destination is multicast |
| st_bcast | output | 1 | Destination is broadcast |

## Verification
The assertions take for granted that a start byte comes with `in_valid`, and that configuration is not rewritten between the twelfth byte of a frame and that frame's decision edge. Under those conditions, the mode-driven outcome one edge after the final address byte is fully determined. The stimulus writes configuration only while the receive port is idle. It always drives `in_sof` together with `in_valid`. It separates frames by idle cycles, and in one case it sends a frame cut short by a fresh start byte, which stays within those assumptions.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;

  localparam logic [1:0] CFG_ADDR_LO = 2'd0;
  localparam logic [1:0] CFG_ADDR_HI = 2'd1;
  localparam logic [1:0] CFG_MODE    = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0]     addr;
    logic [ADDR_BYTES-1:0] mask;
    logic                  en;
    logic                  src;
  } afilt_entry_t;

  typedef struct packed {
    logic report;
    logic mcast_all;
    logic promisc;
  } afilt_mode_t;
endpackage

// File: rtl/afilt_capture.sv
module afilt_capture #(
  parameter int HDR_BYTES = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [7:0]             in_data,
  output logic [HDR_BYTES*8-1:0] hdr_nxt,
  output logic                   done,
  output logic                   sof_acc
);
  localparam int HDR_W = HDR_BYTES * 8;
  localparam int CW    = $clog2(HDR_BYTES + 1);

  logic [CW-1:0]      cnt;
  logic [HDR_W-9:0]   shreg;

  assign sof_acc = in_valid && in_sof;
  assign done    = in_valid && !in_sof && (cnt == CW'(HDR_BYTES - 1));
  assign hdr_nxt = {shreg, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (sof_acc) begin
      cnt   <= CW'(1);
      shreg <= {shreg[HDR_W-17:0], in_data};
    end else if (in_valid && cnt != '0 && cnt < CW'(HDR_BYTES)) begin
      cnt   <= cnt + CW'(1);
      shreg <= {shreg[HDR_W-17:0], in_data};
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HDR_BYTES));
  assert_done_full_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> cnt == CW'(HDR_BYTES));
  assert_sof_restart_R2: assert property (@(posedge clk) disable iff (rst)
    sof_acc |=> cnt == CW'(1));
endmodule

// File: rtl/afilt_match.sv
module afilt_match
  import afilt_pkg::*;
(
  input  afilt_entry_t      entry,
  input  logic [ADDR_W-1:0] da,
  input  logic [ADDR_W-1:0] sa,
  output logic              hit
);
  logic [ADDR_W-1:0]     probe;
  logic [ADDR_BYTES-1:0] byte_ok;

  assign probe = entry.src ? sa : da;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
    assign byte_ok[k] = entry.mask[k] ||
      (probe[ADDR_W-1-8*k -: 8] == entry.addr[ADDR_W-1-8*k -: 8]);
  end

  assign hit = entry.en && (&byte_ok);
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
  import afilt_pkg::*;
#(
  parameter int N_FILT = 31,
  parameter int IW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              go,
  input  logic [N_FILT-1:0] hit,
  input  logic [N_FILT-1:0] src_sel,
  input  logic [N_FILT-1:0] en,
  input  logic [ADDR_W-1:0] da,
  input  afilt_mode_t       mode,
  output logic              dec_valid,
  output logic              dec_pass,
  output logic              st_filt_ok,
  output logic              st_hit,
  output logic [IW-1:0]     st_idx,
  output logic              st_mcast,
  output logic              st_bcast
);
  logic          mc, bc, da_ok, sa_ok, ok, any_hit;
  logic [IW-1:0] win;

  assign mc      = da[ADDR_W-8];
  assign bc      = &da;
  assign any_hit = |hit;
  assign da_ok   = (|(hit & ~src_sel)) || bc || (mc && mode.mcast_all);
  assign sa_ok   = !(|(en & src_sel)) || (|(hit & src_sel));
  assign ok      = da_ok && sa_ok;

  always_comb begin
    win = '0;
    for (int i = N_FILT - 1; i >= 0; i--) begin
      if (hit[i]) win = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_pass   <= 1'b0;
      st_filt_ok <= 1'b0;
      st_hit     <= 1'b0;
      st_idx     <= '0;
      st_mcast   <= 1'b0;
      st_bcast   <= 1'b0;
    end else if (clr) begin
      dec_valid  <= 1'b0;
    end else if (go) begin
      dec_valid  <= 1'b1;
      dec_pass   <= ok || mode.promisc || mode.report;
      st_filt_ok <= ok;
      st_hit     <= any_hit;
      st_idx     <= win;
      st_mcast   <= mc;
      st_bcast   <= bc;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !clr |=> dec_valid && $stable({dec_pass, st_filt_ok, st_hit, st_idx}));
  assert_promisc_R8: assert property (@(posedge clk) disable iff (rst)
    go && mode.promisc |=> dec_pass);
  assert_report_R9: assert property (@(posedge clk) disable iff (rst)
    go && mode.report |=> dec_pass);
  assert_plain_R4: assert property (@(posedge clk) disable iff (rst)
    go && !mode.promisc && !mode.report |=> dec_pass == st_filt_ok);
  assert_idx_zero_R10: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !st_hit |-> st_idx == '0);
  assert_bcast_R7: assert property (@(posedge clk) disable iff (rst)
    dec_valid && st_bcast |-> st_mcast);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int N_FILT = 31,
  parameter int IW     = $clog2(N_FILT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [7:0]    in_data,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_word,
  input  logic [31:0]   cfg_wdata,
  output logic          dec_valid,
  output logic          dec_pass,
  output logic          st_filt_ok,
  output logic          st_hit,
  output logic [IW-1:0] st_idx,
  output logic          st_mcast,
  output logic          st_bcast
);
  localparam int HDR_BYTES = 2 * ADDR_BYTES;

  logic [HDR_BYTES*8-1:0] hdr_nxt;
  logic                   done, sof_acc;
  logic [ADDR_W-1:0]      da, sa;
  afilt_entry_t           tbl [N_FILT];
  afilt_mode_t            mode;
  logic [N_FILT-1:0]      hit, src_sel, en;
  logic                   unused_cfg;

  assign unused_cfg = ^{cfg_wdata[31:26], cfg_wdata[23:22]};

  afilt_capture #(.HDR_BYTES(HDR_BYTES)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .hdr_nxt(hdr_nxt), .done(done), .sof_acc(sof_acc)
  );

  assign da = hdr_nxt[HDR_BYTES*8-1 -: ADDR_W];
  assign sa = hdr_nxt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) mode <= '0;
    else if (cfg_we && cfg_word == CFG_MODE) mode <= afilt_mode_t'(cfg_wdata[2:0]);
  end

  for (genvar i = 0; i < N_FILT; i++) begin : g_ent
    logic sel;
    assign sel = cfg_we && (cfg_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[i] <= '0;
      end else if (sel && cfg_word == CFG_ADDR_LO) begin
        tbl[i].addr[31:0] <= cfg_wdata;
      end else if (sel && cfg_word == CFG_ADDR_HI) begin
        tbl[i].addr[ADDR_W-1:32] <= cfg_wdata[15:0];
        tbl[i].mask              <= cfg_wdata[21:16];
        tbl[i].en                <= cfg_wdata[24];
        tbl[i].src               <= cfg_wdata[25];
      end
    end

    afilt_match u_match (.entry(tbl[i]), .da(da), .sa(sa), .hit(hit[i]));
    assign src_sel[i] = tbl[i].src;
    assign en[i]      = tbl[i].en;
  end

  afilt_decide #(.N_FILT(N_FILT), .IW(IW)) u_dec (
    .clk(clk), .rst(rst), .clr(sof_acc), .go(done), .hit(hit),
    .src_sel(src_sel), .en(en), .da(da), .mode(mode),
    .dec_valid(dec_valid), .dec_pass(dec_pass), .st_filt_ok(st_filt_ok),
    .st_hit(st_hit), .st_idx(st_idx), .st_mcast(st_mcast), .st_bcast(st_bcast)
  );

  assert_sof_clears_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof |=> !dec_valid);
  assert_rise_on_byte_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_valid) |-> $past(in_valid && !in_sof));
  assert_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    (hit & ~en) == '0);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !dec_valid && !dec_pass && !st_hit);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int NF = 31;
  localparam int IW = 5;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sof = 0;
  logic [7:0] in_data = 0;
  logic cfg_we = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [1:0] cfg_word = 0;
  logic [31:0] cfg_wdata = 0;
  logic dec_valid, dec_pass, st_filt_ok, st_hit, st_mcast, st_bcast;
  logic [IW-1:0] st_idx;

  always #5 clk = ~clk;

  rx_addr_filter #(.N_FILT(NF)) u_rx_addr_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .dec_pass(dec_pass), .st_filt_ok(st_filt_ok),
    .st_hit(st_hit), .st_idx(st_idx), .st_mcast(st_mcast), .st_bcast(st_bcast)
  );

  typedef struct packed {
    logic pass, ok, hit;
    logic [IW-1:0] idx;
    logic mc, bc;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, errors = 0;
  logic [47:0] m_addr [NF];
  logic [5:0]  m_mask [NF];
  logic        m_en [NF], m_src [NF];
  logic [2:0]  m_mode = 0;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [47:0] da, input logic [47:0] sa);
    exp_t e;
    logic dok, sany, shit, mt;
    e = '0; dok = 0; sany = 0; shit = 0;
    e.mc = da[40];
    e.bc = (da == 48'hFFFF_FFFF_FFFF);
    for (int i = NF - 1; i >= 0; i--) begin
      mt = m_en[i];
      for (int k = 0; k < 6; k++)
        if (!m_mask[i][k] && ((m_src[i] ? sa : da) >> (40 - 8*k)) % 256 != (m_addr[i] >> (40 - 8*k)) % 256)
          mt = 0;
      if (m_en[i] && m_src[i]) sany = 1;
      if (mt) begin
        e.hit = 1; e.idx = IW'(i);
        if (m_src[i]) shit = 1; else dok = 1;
      end
    end
    if (e.bc || (e.mc && m_mode[1])) dok = 1;
    e.ok = dok && (!sany || shit);
    e.pass = e.ok || m_mode[0] || m_mode[2];
    return e;
  endfunction

  task automatic cfg(input int idx, input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_word = w; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (w == 2) m_mode = d[2:0];
    else if (idx < NF) begin
      if (w == 0) m_addr[idx][31:0] = d;
      else begin
        m_addr[idx][47:32] = d[15:0]; m_mask[idx] = d[21:16];
        m_en[idx] = d[24]; m_src[idx] = d[25];
      end
    end
  endtask

  task automatic set_entry(input int idx, input logic [47:0] a, input logic [5:0] mk,
                           input logic e, input logic s);
    cfg(idx, 0, a[31:0]);
    cfg(idx, 1, {6'd0, s, e, 2'd0, mk, a[47:32]});
  endtask

  task automatic send(input logic [47:0] da, input logic [47:0] sa, input int extra);
    exp_t e;
    logic [95:0] hdr;
    int total;
    e = model(da, sa);
    sb_q.push_back(e);
    hdr = {da, sa};
    total = 12 + extra;
    for (int b = 0; b < total; b++) begin
      @(negedge clk);
      if (b == 12) check(dec_valid === 1'b1, "R2 timing", 64'(dec_valid), 1);
      in_valid = 1; in_sof = (b == 0);
      in_data = (b < 12) ? hdr[95 - 8*b -: 8] : 8'(b * 37);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    if (total == 12) check(dec_valid === 1'b1, "R2 timing", 64'(dec_valid), 1);
    else check(dec_valid === 1'b1 && dec_pass === e.pass && st_idx === e.idx,
               "R2 hold", 64'({dec_valid, dec_pass, st_idx}), 64'({1'b1, e.pass, e.idx}));
    repeat (2) @(negedge clk);
  endtask

  initial begin : monitor
    logic prev;
    exp_t e, got;
    prev = 0;
    forever begin
      @(negedge clk);
      if (!rst && dec_valid && !prev) begin
        got = {dec_pass, st_filt_ok, st_hit, st_idx, st_mcast, st_bcast};
        if (sb_q.size() == 0) check(0, "R2 unexpected decision", 64'(got), 0);
        else begin
          e = sb_q.pop_front();
          check(got === e, "R4-R11 decision", 64'(got), 64'(e));
        end
      end
      prev = dec_valid;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [47:0] A  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] B  = 48'h02_AA_BB_CC_00_00;
  localparam logic [47:0] S  = 48'h06_00_00_00_00_07;
  localparam logic [47:0] SX = 48'h0A_0B_0C_0D_0E_0F;
  localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;

  initial begin
    for (int i = 0; i < NF; i++) begin
      m_addr[i] = 0; m_mask[i] = 0; m_en[i] = 0; m_src[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!dec_valid && !dec_pass && !st_hit && st_idx == 0 && !st_filt_ok && !st_mcast && !st_bcast,
          "R1 reset", 64'({dec_valid, dec_pass, st_hit, st_idx}), 0);
    // R11: everything-masked entry left disabled
    set_entry(1, 48'h0, 6'h3F, 0, 0);
    set_entry(0, A, 6'h00, 1, 0);
    set_entry(5, A, 6'h00, 1, 0);
    send(A, SX, 0);                       // R4, R10 lowest index wins
    send(48'h02_11_22_33_44_56, SX, 3);   // R4 miss, R2 hold, R11
    set_entry(3, B, 6'b110000, 1, 0);
    send(48'h02_AA_BB_CC_12_34, SX, 0);   // R5
    send(48'h02_AA_BB_CD_12_34, SX, 0);   // R5 unmasked byte differs
    send(48'hFFFF_FFFF_FFFF, SX, 0);      // R7 broadcast
    send(MC, SX, 0);                      // R7 multicast, mode off
    cfg(0, 2, 32'h2);
    send(MC, SX, 0);                      // R7 accept-all-multicast
    cfg(0, 2, 32'h0);
    set_entry(7, S, 6'h00, 1, 1);
    send(A, S, 0);                        // R6 source match
    send(A, SX, 0);                       // R6 source miss
    send(48'h02_00_00_00_00_09, S, 0);    // R6/R10 only source hit
    set_entry(7, S, 6'h00, 0, 1);
    send(A, SX, 0);                       // R6 no source entry
    cfg(0, 2, 32'h1);
    send(48'h02_99_99_99_99_99, SX, 2);   // R8 promiscuous
    cfg(0, 2, 32'h4);
    send(48'h02_99_99_99_99_99, SX, 0);   // R9 report-all
    send(A, SX, 0);                       // R9 with hit
    cfg(0, 2, 32'h0);
    set_entry(31, 48'h0, 6'h3F, 1, 0);    // R3 out-of-range write ignored
    send(48'h02_99_99_99_99_99, SX, 0);
    // R2 cut-short frame: no decision, restart counts
    @(negedge clk);
    in_valid = 1; in_sof = 1; in_data = 8'h02;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      in_sof = 0; in_data = 8'hEE;
    end
    @(negedge clk);
    in_valid = 0;
    check(dec_valid === 1'b0, "R2 sof clears", 64'(dec_valid), 0);
    send(A, SX, 0);
    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R2 missing decision", 64'(sb_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule